// File: doc/BRIEF.md
# Interrupt Status and Mask Register Set

This block holds the interrupt state of a USB host controller and exposes it on a plain register bus. The controller core raises single-cycle event pulses. Each pulse latches a sticky flag in a status word, and software clears a flag by writing a one to it. A mask word decides which flags may interrupt the processor. The mask can be reached at two addresses. A write to the first address sets the mask bits that are written as one, and a write to the second address clears them. Either address reads back the same mask, so software never has to read, modify and write the mask to change one bit.

The top bit of the mask is a global gate. The single interrupt line is high only while that gate is set and at least one status flag is set together with its own mask bit. Eight event sources are supported. Seven of them occupy the low status bits, and the eighth sits just below the gate bit. Every other bit position is hard-wired to zero.

Top module: `irq_regset`

## Requirements
- R1: After reset every status flag and every mask bit is zero, `irq_o` is low, and all three registers read as zero.
- R2: A pulse on `evt_i[k]` sets status bit k for k = 0..6 and status bit 30 for k = 7, one clock after the pulse. The flag stays set until software clears it.
- R3: A write to the status address (byte offset 0x0) clears each status bit written as one and leaves bits written as zero unchanged.
- R4: When an event pulse and a clear of the same status bit land in the same cycle, the bit ends up set.
- R5: A write to the enable address (byte offset 0x4) sets each mask bit written as one and leaves the other mask bits as they were.
- R6: A write to the disable address (byte offset 0x8) clears each mask bit written as one and leaves the other mask bits as they were.
- R7: Reads at offset 0x4 and at offset 0x8 both return the current mask.
- R8: Only bits 0..6 and 30 exist in the status word, and only bits 0..6, 30 and 31 exist in the mask. All other bits read zero and ignore writes. Any address other than 0x0, 0x4 or 0x8 reads zero, and a write to it changes no state.
- R9: `irq_o` is high exactly when mask bit 31 is set and some status bit in 0..30 is set together with the mask bit at the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from registered state |
| evt_i | input | 8 | Event pulses from the controller core |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted status flag shows up in the very next read of offset 0x0. If its mask bit and the gate are set, it also shows up on `irq_o` in the same cycle. A corrupted mask bit shows up at both alias addresses at once. If the mask error is in bit 31, every pending interrupt appears or disappears together, so the reference model compares both outputs after every edge. A fault is therefore reported within one cycle of the first stimulus that exposes it. Long random runs interleave pulses, clears and mask writes so that collisions between sets and clears occur many times.

// File: rtl/irq_regset_pkg.sv
package irq_regset_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_SRC    = 8;
    localparam int LOW_SRC    = 7;
    localparam int HIGH_POS   = 30;
    localparam int MASTER_BIT = 31;

    // bit position of event source idx in the status word
    function automatic int src_pos(input int idx);
        return (idx < LOW_SRC) ? idx : HIGH_POS + (idx - LOW_SRC);
    endfunction

    function automatic logic [REG_W-1:0] src_bits();
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_SRC; i++) v[src_pos(i)] = 1'b1;
        return v;
    endfunction

    localparam logic [REG_W-1:0] STATUS_LEGAL = src_bits();
    localparam logic [REG_W-1:0] MASTER_ONE   = REG_W'(1) << MASTER_BIT;
    localparam logic [REG_W-1:0] MASK_LEGAL   = STATUS_LEGAL | MASTER_ONE;

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_regset_pkg::*;
(
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [REG_W-1:0]   evt_vec
);
    logic [REG_W-1:0] vec_d;

    always_comb begin
        vec_d = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            vec_d[src_pos(i)] = evt_i[i];
        end
    end

    assign evt_vec = vec_d;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_regset_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] status_q
);
    typedef struct packed {
        logic [REG_W-1:0] flags;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a pending set beats a clear of the same bit
        st_d.flags = ((st_q.flags & ~clr_vec) | set_vec) & STATUS_LEGAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q.flags;

    for (genvar b = 0; b < REG_W; b++) begin : g_chk
        if (STATUS_LEGAL[b]) begin : g_live
            a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[b] |=> status_q[b]);
            a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[b] && !set_vec[b]) |=> !status_q[b]);
            a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[b] && !clr_vec[b]) |=> status_q[b]);
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_regset_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] mask_q
);
    typedef struct packed {
        logic [REG_W-1:0] bits;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        mk_d.bits = ((mk_q.bits | set_vec) & ~clr_vec) & MASK_LEGAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign mask_q = mk_q.bits;

    for (genvar b = 0; b < REG_W; b++) begin : g_chk
        if (MASK_LEGAL[b]) begin : g_live
            a_r5_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (set_vec[b] && !clr_vec[b]) |=> mask_q[b]);
            a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[b] && !set_vec[b]) |=> !mask_q[b]);
        end
    end
endmodule

// File: rtl/irq_regset.sv
module irq_regset
    import irq_regset_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] OFS_STATUS  = ADDR_W'(0),
    parameter logic [ADDR_W-1:0] OFS_ENABLE  = ADDR_W'(4),
    parameter logic [ADDR_W-1:0] OFS_DISABLE = ADDR_W'(8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                reg_we,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_SRC-1:0]  evt_i,
    output logic                irq_o
);
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] stat_clr_d;
    logic [REG_W-1:0] mask_set_d;
    logic [REG_W-1:0] mask_clr_d;
    logic [REG_W-1:0] rdata_d;
    logic             irq_d;

    irq_src_map u_map (
        .evt_i   (evt_i),
        .evt_vec (evt_vec)
    );

    always_comb begin
        stat_clr_d = '0;
        mask_set_d = '0;
        mask_clr_d = '0;
        if (reg_we) begin
            if (reg_addr == OFS_STATUS)  stat_clr_d = reg_wdata;
            if (reg_addr == OFS_ENABLE)  mask_set_d = reg_wdata;
            if (reg_addr == OFS_DISABLE) mask_clr_d = reg_wdata;
        end
    end

    irq_status_bank u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (evt_vec),
        .clr_vec  (stat_clr_d),
        .status_q (status_q)
    );

    irq_mask_bank u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (mask_set_d),
        .clr_vec (mask_clr_d),
        .mask_q  (mask_q)
    );

    always_comb begin
        rdata_d = '0;
        if (reg_addr == OFS_STATUS)                                 rdata_d = status_q;
        else if (reg_addr == OFS_ENABLE || reg_addr == OFS_DISABLE) rdata_d = mask_q;
        irq_d = mask_q[MASTER_BIT] && ((status_q & mask_q & ~MASTER_ONE) != '0);
    end

    assign reg_rdata = rdata_d;
    assign irq_o     = irq_d;

    a_r9_gate_required: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> mask_q[MASTER_BIT]);
    a_r9_source_required: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_q != '0));
    a_r8_no_stray_status: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_q & ~STATUS_LEGAL) == 0);
endmodule

// File: tb/sim_irq_regset.sv
module sim_irq_regset;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_stat = '0;
    logic [31:0] m_mask = '0;

    localparam logic [31:0] ST_OK = 32'h4000_007F;
    localparam logic [31:0] MK_OK = 32'hC000_007F;

    always #5 clk = ~clk;

    irq_regset u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    function automatic logic [31:0] evt_to_bits(input logic [7:0] e);
        int pos [8] = '{0, 1, 2, 3, 4, 5, 6, 30};
        logic [31:0] v = '0;
        for (int i = 0; i < 8; i++) if (e[i]) v[pos[i]] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a == 4'h0) return m_stat;
        if (a == 4'h4 || a == 4'h8) return m_mask;
        return 32'h0;
    endfunction

    function automatic logic model_irq();
        return m_mask[31] && ((m_stat & m_mask & 32'h7FFF_FFFF) != 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle plus events; model updated at the edge, outputs compared after it
    task automatic step(input string req, input logic [3:0] a, input logic we,
                        input logic [31:0] wd, input logic [7:0] ev);
        logic [31:0] clr;
        reg_addr = a; reg_we = we; reg_wdata = wd; evt_i = ev;
        @(posedge clk);
        clr = (we && a == 4'h0) ? wd : 32'h0;
        m_stat = ((m_stat & ~clr) | evt_to_bits(ev)) & ST_OK;
        if (we && a == 4'h4) m_mask = m_mask | (wd & MK_OK);
        if (we && a == 4'h8) m_mask = m_mask & ~(wd & MK_OK);
        @(negedge clk);
        check(req, reg_rdata, model_read(a));
        check("R9", {31'h0, irq_o}, {31'h0, model_irq()});
        reg_we = 1'b0; evt_i = '0;
    endtask

    task automatic read_at(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a; reg_we = 1'b0; evt_i = '0;
        #1;
        check(req, reg_rdata, exp);
        check(req, reg_rdata, model_read(a));
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_at("R1", 4'h0, 32'h0);
        read_at("R1", 4'h4, 32'h0);
        read_at("R1", 4'h8, 32'h0);
        check("R1", {31'h0, irq_o}, 32'h0);

        // R2 each source lands on its own bit
        for (int k = 0; k < 8; k++) begin
            step("R2", 4'h0, 1'b0, 32'h0, 8'(1 << k));
        end
        read_at("R2", 4'h0, 32'h4000_007F);

        // R3 partial clear
        step("R3", 4'h0, 1'b1, 32'h0000_0005, 8'h00);
        read_at("R3", 4'h0, 32'h4000_007A);
        step("R3", 4'h0, 1'b1, 32'hFFFF_FFFF, 8'h00);
        read_at("R3", 4'h0, 32'h0);

        // R4 collision: clear bit 3 and pulse source 3 together
        step("R4", 4'h0, 1'b0, 32'h0, 8'h08);
        step("R4", 4'h0, 1'b1, 32'h0000_0008, 8'h08);
        read_at("R4", 4'h0, 32'h0000_0008);

        // R5 / R7 enable sets, both aliases read it
        step("R5", 4'h4, 1'b1, 32'h0000_0009, 8'h00);
        read_at("R7", 4'h8, 32'h0000_0009);
        read_at("R7", 4'h4, 32'h0000_0009);
        check("R9", {31'h0, irq_o}, 32'h0);   // gate still off

        // R9 gate on -> irq from bit 3
        step("R9", 4'h4, 1'b1, 32'h8000_0000, 8'h00);
        check("R9", {31'h0, irq_o}, 32'h1);

        // R6 disable clears only bit 3
        step("R6", 4'h8, 1'b1, 32'h0000_0008, 8'h00);
        read_at("R6", 4'h4, 32'h8000_0001);
        check("R9", {31'h0, irq_o}, 32'h0);

        // R8 undefined mask bits ignored, unmapped address inert
        step("R8", 4'h4, 1'b1, 32'hFFFF_FFFF, 8'h00);
        read_at("R8", 4'h8, 32'hC000_007F);
        step("R8", 4'hC, 1'b1, 32'hFFFF_FFFF, 8'h00);
        read_at("R8", 4'hC, 32'h0);
        read_at("R8", 4'h0, 32'h0000_0008);
        read_at("R8", 4'h4, 32'hC000_007F);
        step("R8", 4'h0, 1'b1, 32'h0000_0008, 8'h80);
        read_at("R8", 4'h0, 32'h4000_0000);
        check("R9", {31'h0, irq_o}, 32'h1);

        // random mix compared to the model every clock
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 2000; n++) begin
            logic [3:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {lfsr[5:4], 2'b00} | {2'b00, lfsr[7:6] & {2{lfsr[8]}}};
            step("R2", a, lfsr[9] & lfsr[10], {lfsr[15:0], lfsr[31:16]} ^ lfsr,
                 lfsr[18:11] & lfsr[26:19]);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule